// File: doc/BRIEF.md
# Nonlinear shift-register keystream core

This block is the single-step engine of a small stream cipher. It holds a 117-bit state made of three nonlinear shift registers and a two-nibble feedback register. On each step it takes one input byte, mixes it with the feedback nibbles, and injects the mixed bits into the three shift registers. Each shift register computes a new head cell with an end-around-carry addition of two of its cells. One step also forms a 4-bit output nibble from the successor state and shifts that nibble into the feedback register.

A controller loads a full state through the load port. It then issues step strobes with input bytes and reads the current state and output nibble back after each step. One step completes in one clock cycle, so steps may be issued back to back. Key scheduling and message sequencing sit outside this block.

Top module: `ks_core`

## Requirements
- R1: While `rst_n` is low, all 117 state bits are cleared to zero asynchronously, and `nibble_out` reads 0.
- R2: State layout, with bit 0 of every cell as its least significant bit:
  - Left cell l(i) occupies bits [5i+4:5i], for i = 0..6.
  - Middle cell m(j) occupies bits [35+7j+6:35+7j], for j = 0..6.
  - Right cell r(k) occupies bits [84+5k+4:84+5k], for k = 0..4.
  - Feedback nibble f0 occupies [112:109] and f1 occupies [116:113].
  - `nibble_out` always equals the f1 field of `state_out`.
- R3: When `load_en` is high at a clock edge, `state_out` equals `load_state` after that edge, whether or not `step_en` is high.
- R4: When both `load_en` and `step_en` are low, the state does not change.
- R5: A step uses a mixed byte b = `in_byte` XOR {f1, f0}, with f0 in bits 0..3 of the concatenation.
- R6: Left update:
  - New l0 = l3 ⊞ rot(l6).
  - New l3 = l2 XOR b[7:3].
  - New l1, l2, l4, l5 and l6 take the old l0, l1, l3, l4 and l5.
- R7: Middle update:
  - New m0 = m5 ⊞ rot(m6).
  - New m5 = m4 XOR {b[2:0], b[7:4]}.
  - New m1 to m4 take the old m0 to m3, and new m6 takes the old m5.
- R8: Right update:
  - New r0 = r2 ⊞ r4, with no rotation.
  - New r2 = r1 XOR b[4:0].
  - New r1, r3 and r4 take the old r0, r2 and r3.
- R9: For n-bit operands, x ⊞ y is (x+y) mod (2^n−1). The result is 0 only when both operands are 0. A nonzero sum that is congruent to 0 gives 2^n−1.
- R10: rot(x) moves bit 0 of a cell to the top bit and moves every other bit down by one position.
- R11: Output bit i, for i = 0..3, is chosen by bit i+3 of the new m0:
  - When that bit is 0, output bit i is bit i+1 of (new l0 XOR new l4).
  - When that bit is 1, output bit i is bit i+1 of (new r0 XOR new r3).
- R12: On a step, new f0 = old f1 and new f1 = the output nibble. Each step takes one clock, and consecutive steps chain without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Replace the state with `load_state` at the next edge |
| load_state | input | 117 | Full state to load, in the layout of R2 |
| step_en | input | 1 | Perform one cipher step at the next edge |
| in_byte | input | 8 | Input byte consumed by a step |
| state_out | output | 117 | Current state |
| nibble_out | output | 4 | Most recent output nibble (f1 field) |

## Verification
The assertions assume that `load_en`, `step_en`, `load_state` and `in_byte` are synchronous to `clk` and settled at each rising edge. Any 117-bit value is accepted as a loadable state, so no property depends on a restricted state space. The stimulus changes every input on the falling edge only. It covers arbitrary random states and bytes, including load and step in the same cycle and idle gaps between steps.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int L_CELLS = 7;
  localparam int L_W     = 5;
  localparam int M_CELLS = 7;
  localparam int M_W     = 7;
  localparam int R_CELLS = 5;
  localparam int R_W     = 5;
  localparam int F_W     = 4;
  localparam int BYTE_W  = 8;

  localparam int L_BITS  = L_CELLS * L_W;
  localparam int M_BITS  = M_CELLS * M_W;
  localparam int R_BITS  = R_CELLS * R_W;

  localparam int L_OFS   = 0;
  localparam int M_OFS   = L_OFS + L_BITS;
  localparam int R_OFS   = M_OFS + M_BITS;
  localparam int F0_OFS  = R_OFS + R_BITS;
  localparam int F1_OFS  = F0_OFS + F_W;
  localparam int STATE_W = F1_OFS + F_W;

  typedef logic [STATE_W-1:0] ks_state_t;
endpackage

// File: rtl/ks_eac_add.sv
// n-bit end-around-carry adder: (a+b) mod (2^n-1), zero only for 0+0.
module ks_eac_add #(
  parameter int W = 5
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    // carry wraps back in; a set carry means raw[W-1:0] <= 2^W-2, no overflow
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/ks_lane_next.sv
// Successor of one nonlinear shift register: head cell from an
// end-around-carry sum of two taps, one cell receives injected bits,
// the others shift up by one cell.
module ks_lane_next #(
  parameter int CELLS = 7,
  parameter int W     = 5,
  parameter int TAP_A = 3,
  parameter int TAP_B = 6,
  parameter int INJ   = 3,
  parameter bit ROT_B = 1'b1,
  localparam int LW   = CELLS * W
) (
  input  logic [LW-1:0] cells_i,
  input  logic [W-1:0]  inj_i,
  output logic [LW-1:0] cells_o
);
  logic [W-1:0] op_b;

  generate
    if (ROT_B) begin : g_rot
      // bit 0 goes to the top, the rest move down one place
      assign op_b = {cells_i[TAP_B*W], cells_i[TAP_B*W+W-1 : TAP_B*W+1]};
    end else begin : g_norot
      assign op_b = cells_i[TAP_B*W +: W];
    end
  endgenerate

  ks_eac_add #(.W(W)) u_head (
    .a_i  (cells_i[TAP_A*W +: W]),
    .b_i  (op_b),
    .sum_o(cells_o[0 +: W])
  );

  for (genvar c = 1; c < CELLS; c++) begin : g_cell
    if (c == INJ) begin : g_inj
      assign cells_o[c*W +: W] = cells_i[(c-1)*W +: W] ^ inj_i;
    end else begin : g_shift
      assign cells_o[c*W +: W] = cells_i[(c-1)*W +: W];
    end
  end
endmodule

// File: rtl/ks_nib_sel.sv
// Per-bit choice between the left and right mixes under middle-cell control.
module ks_nib_sel #(
  parameter int NW = 4
) (
  input  logic [NW-1:0] lmix_i,
  input  logic [NW-1:0] rmix_i,
  input  logic [NW-1:0] sel_i,
  output logic [NW-1:0] nib_o
);
  for (genvar i = 0; i < NW; i++) begin : g_bit
    assign nib_o[i] = sel_i[i] ? rmix_i[i] : lmix_i[i];
  end
endmodule

// File: rtl/ks_core.sv
module ks_core
  import ks_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_state,
  input  logic               step_en,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic [STATE_W-1:0] state_out,
  output logic [F_W-1:0]     nibble_out
);
  ks_state_t state_q, state_d, succ;

  logic [F_W-1:0]    f0, f1, nib;
  logic [BYTE_W-1:0] mixb;
  logic [L_BITS-1:0] l_nx;
  logic [M_BITS-1:0] m_nx;
  logic [R_BITS-1:0] r_nx;
  logic [F_W-1:0]    lmix, rmix, msel;

  assign f0   = state_q[F0_OFS +: F_W];
  assign f1   = state_q[F1_OFS +: F_W];
  assign mixb = in_byte ^ {f1, f0};

  ks_lane_next #(
    .CELLS(L_CELLS), .W(L_W), .TAP_A(3), .TAP_B(6), .INJ(3), .ROT_B(1'b1)
  ) u_left (
    .cells_i(state_q[L_OFS +: L_BITS]),
    .inj_i  (mixb[7:3]),
    .cells_o(l_nx)
  );

  ks_lane_next #(
    .CELLS(M_CELLS), .W(M_W), .TAP_A(5), .TAP_B(6), .INJ(5), .ROT_B(1'b1)
  ) u_mid (
    .cells_i(state_q[M_OFS +: M_BITS]),
    .inj_i  ({mixb[2:0], mixb[7:4]}),
    .cells_o(m_nx)
  );

  ks_lane_next #(
    .CELLS(R_CELLS), .W(R_W), .TAP_A(2), .TAP_B(4), .INJ(2), .ROT_B(1'b0)
  ) u_right (
    .cells_i(state_q[R_OFS +: R_BITS]),
    .inj_i  (mixb[4:0]),
    .cells_o(r_nx)
  );

  // new l0 ^ new l4, new r0 ^ new r3, bits 1..4; selector = new m0 bits 3..6
  assign lmix = l_nx[4:1] ^ l_nx[4*L_W+1 +: F_W];
  assign rmix = r_nx[4:1] ^ r_nx[3*R_W+1 +: F_W];
  assign msel = m_nx[3 +: F_W];

  ks_nib_sel #(.NW(F_W)) u_sel (
    .lmix_i(lmix),
    .rmix_i(rmix),
    .sel_i (msel),
    .nib_o (nib)
  );

  assign succ = {nib, f1, r_nx, m_nx, l_nx};

  always_comb begin
    state_d = state_q;
    if (load_en)      state_d = load_state;
    else if (step_en) state_d = succ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state_out  = state_q;
  assign nibble_out = state_q[F1_OFS +: F_W];
endmodule

// File: rtl/ks_core_chk.sv
module ks_core_chk
  import ks_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_en,
  input logic [STATE_W-1:0] load_state,
  input logic               step_en,
  input logic [STATE_W-1:0] state_out
);
  logic do_step;
  assign do_step = step_en && !load_en;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_clear_chk: assert (state_out == '0);
    end
  end

  // R3
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> state_out == $past(load_state));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(state_out));

  // R12
  fb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> state_out[F0_OFS +: F_W] == $past(state_out[F1_OFS +: F_W]));

  // R6
  left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> state_out[L_W +: L_W] == $past(state_out[0 +: L_W]));

  // R8
  right_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> state_out[R_OFS+4*R_W +: R_W] == $past(state_out[R_OFS+3*R_W +: R_W]));

  // R9
  eac_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && (state_out[3*L_W +: L_W] != '0 || state_out[6*L_W +: L_W] != '0))
      |=> state_out[0 +: L_W] != '0);
endmodule

bind ks_core ks_core_chk u_ks_core_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .load_state(load_state),
  .step_en   (step_en),
  .state_out (state_out)
);

// File: tb/tb_ks_core.sv
module tb_ks_core;
  logic         clk;
  logic         rst_n;
  logic         load_en;
  logic [116:0] load_state;
  logic         step_en;
  logic [7:0]   in_byte;
  logic [116:0] state_out;
  logic [3:0]   nibble_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [116:0] model;
  logic [116:0] exp_q[$];
  string        tag_q[$];

  ks_core dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_state(load_state),
    .step_en(step_en), .in_byte(in_byte), .state_out(state_out),
    .nibble_out(nibble_out)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int madd(int x, int y, int n);
    int md = (1 << n) - 1;
    int s  = x + y;
    int rr;
    if (s == 0) return 0;
    rr = s % md;
    return (rr == 0) ? md : rr;
  endfunction

  function automatic int rotc(int x, int n);
    return (x >> 1) | ((x & 1) << (n - 1));
  endfunction

  function automatic logic [116:0] model_step(logic [116:0] s, logic [7:0] a);
    int l[7], m[7], r[5], nl[7], nm[7], nr[5];
    int f0, f1, b, bm, nib, bitv;
    logic [116:0] o;
    for (int i = 0; i < 7; i++) begin
      l[i] = int'(s[5*i +: 5]);
      m[i] = int'(s[35+7*i +: 7]);
    end
    for (int i = 0; i < 5; i++) r[i] = int'(s[84+5*i +: 5]);
    f0 = int'(s[112:109]);
    f1 = int'(s[116:113]);
    b  = int'(a) ^ (f0 | (f1 << 4));
    nl[0] = madd(l[3], rotc(l[6], 5), 5);
    nl[1] = l[0]; nl[2] = l[1]; nl[3] = l[2] ^ ((b >> 3) & 31);
    nl[4] = l[3]; nl[5] = l[4]; nl[6] = l[5];
    bm = ((b >> 4) & 15) | ((b & 7) << 4);
    nm[0] = madd(m[5], rotc(m[6], 7), 7);
    nm[1] = m[0]; nm[2] = m[1]; nm[3] = m[2]; nm[4] = m[3];
    nm[5] = m[4] ^ bm; nm[6] = m[5];
    nr[0] = madd(r[2], r[4], 5);
    nr[1] = r[0]; nr[2] = r[1] ^ (b & 31); nr[3] = r[2]; nr[4] = r[3];
    nib = 0;
    for (int i = 0; i < 4; i++) begin
      if (((nm[0] >> (i + 3)) & 1) == 1) bitv = ((nr[0] ^ nr[3]) >> (i + 1)) & 1;
      else                               bitv = ((nl[0] ^ nl[4]) >> (i + 1)) & 1;
      nib = nib | (bitv << i);
    end
    for (int i = 0; i < 7; i++) begin
      o[5*i +: 5]    = nl[i][4:0];
      o[35+7*i +: 7] = nm[i][6:0];
    end
    for (int i = 0; i < 5; i++) o[84+5*i +: 5] = nr[i][4:0];
    o[112:109] = f1[3:0];
    o[116:113] = nib[3:0];
    return o;
  endfunction

  function automatic logic [116:0] rand_state();
    logic [127:0] t = {$urandom, $urandom, $urandom, $urandom};
    return t[116:0];
  endfunction

  // driver: applies one cycle of stimulus and queues the expected state
  task automatic drive(input logic ld, input logic [116:0] lst, input logic st,
                       input logic [7:0] byt, input string tag);
    @(negedge clk);
    load_en    = ld;
    load_state = lst;
    step_en    = st;
    in_byte    = byt;
    if (ld)      model = lst;
    else if (st) model = model_step(model, byt);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each rising edge
  initial begin
    logic [116:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (state_out !== e) begin
          errors++;
          $display("FAIL %s: state actual %h expected %h", t, state_out, e);
        end
        checks++;
        if (nibble_out !== e[116:113]) begin
          errors++;
          $display("FAIL R2 nibble (%s): actual %h expected %h", t, nibble_out, e[116:113]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [116:0] s;
    int dice;
    rst_n = 0; load_en = 0; step_en = 0; load_state = '0; in_byte = '0;
    model = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (state_out !== '0 || nibble_out !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset: actual %h/%h expected 0/0", state_out, nibble_out);
    end
    rst_n = 1;

    drive(0, '0, 0, 8'h00, "R4 idle after reset");
    drive(0, '0, 0, 8'h5A, "R4 idle with byte present");

    // R9: all-zero operands stay zero
    drive(1, '0, 0, 8'h00, "R3 load zero");
    drive(0, '0, 1, 8'h00, "R9 both operands zero");
    // R9: all-ones cells, sum congruent zero gives all ones
    drive(1, {117{1'b1}}, 0, 8'h00, "R3 load all ones");
    drive(0, '0, 1, 8'h00, "R9 congruent-zero sum");
    // R10: only l6 bit 0 set, head becomes top bit
    s = '0; s[30] = 1'b1; s[35+6*7] = 1'b1;
    drive(1, s, 0, 8'h00, "R3 load rotation probe");
    drive(0, '0, 1, 8'h00, "R10 rotation of single bit");
    // R3 priority
    s = rand_state();
    drive(1, s, 1, 8'hA5, "R3 load wins over step");
    drive(0, '0, 0, 8'h00, "R4 hold after load");
    // R5..R8 byte injection from zero state
    drive(1, '0, 0, 8'h00, "R3 load zero");
    drive(0, '0, 1, 8'hFF, "R5 R6 R7 R8 inject 0xFF");
    drive(0, '0, 1, 8'h01, "R5 R6 R7 R8 inject 0x01");
    drive(0, '0, 1, 8'h80, "R5 R6 R7 R8 inject 0x80");
    // R5: byte equal to feedback cancels to zero mix
    s = '0; s[112:109] = 4'h3; s[116:113] = 4'hC;
    drive(1, s, 0, 8'h00, "R3 load feedback probe");
    drive(0, '0, 1, 8'hC3, "R5 byte cancels feedback");
    // R11 R12 back-to-back steps from random states
    for (int k = 0; k < 6; k++) begin
      drive(1, rand_state(), 0, 8'h00, "R3 load random");
      for (int j = 0; j < 8; j++)
        drive(0, '0, 1, 8'($urandom), "R11 R12 back-to-back step");
    end
    // random mix
    for (int k = 0; k < 400; k++) begin
      dice = $urandom % 10;
      if (dice == 0)      drive(1, rand_state(), ($urandom % 2) == 1, 8'($urandom), "R3 random load");
      else if (dice == 1) drive(0, rand_state(), 0, 8'($urandom), "R4 random idle");
      else                drive(0, '0, 1, 8'($urandom), "R6 R7 R8 R11 R12 random step");
    end
    drive(0, '0, 0, 8'h00, "R4 final idle");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule